// File: doc/BRIEF.md
# Iteration Sequencer for a Shared Floating-Point Datapath

This block is the control unit for a chaotic-map generator in which a single floating-point multiplier and a single floating-point adder/subtractor are shared across every operation of one iteration. It steps through a fixed ring of thirteen phases. Each phase owns one arithmetic operation. Eight phases are products, four are the sums and differences of the discretized map, and the last adds a positive offset to the x variable so that a unipolar converter can follow it.

A phase is held for a fixed number of clock cycles, long enough for the slower arithmetic unit to return its result. The phase number is exported as a select code. That code steers the operand multiplexers (four 32-bit 8-to-1 selectors) and the result distributor. A multiply enable marks the product phases. Thirteen load strobes, one per 32-bit data register, capture each result once it is valid.

All outputs come straight from flip-flops, so the strobes are free of glitches.

Top module: `iter_sequencer`

## Requirements
- R1: While reset (`rst`, synchronous, active high) is asserted, and in the first cycle after it is released, `phase_sel` is 0, every bit of `load_stb` is 0 and `mul_en` is 0. The first strobe after release comes on the 11th cycle.
- R2: Each phase lasts exactly 11 clock cycles, and `phase_sel` holds steady within a phase.
- R3: `phase_sel` advances by one at each phase boundary, running 0,1,…,12, and returns from 12 to 0. One pass through the thirteen phases is one iteration.
- R4: Bit k of `load_stb` is high for exactly one cycle per pass. That cycle is the last (11th) cycle of phase k, which is 10 cycles after the phase begins.
- R5: At most one bit of `load_stb` is high in any cycle, and all bits are low in the first ten cycles of every phase.
- R6: `mul_en` is high throughout phases 0 to 7 (the eight products) and low throughout phases 8 to 12 (the four map sums and the offset add). The only exception is the R1 cycle just after reset.
- R7: Asserting reset in the middle of an iteration restarts the sequence from the first cycle of phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| phase_sel | output | 4 | Current phase; select code for the operand multiplexers and the result distributor |
| mul_en | output | 1 | Multiplier enable, high in product phases |
| load_stb | output | 13 | One-hot load strobes, bit k loads data register k |

## Verification
The bench targets the phase boundaries. A counter that wrapped at 10 or 12 instead of 11 would shift every later strobe and select change, and a wrong wrap from phase 12 would show up as a select value of 13. It also watches the cycle right after reset: a design that decoded the multiply enable from the current phase rather than registering it would show `mul_en` high there. Resets are injected at random points in the iteration, so a counter that failed to clear would emit its next strobe early rather than 11 cycles after release.

// File: rtl/iter_seq_pkg.sv
package iter_seq_pkg;
    localparam int NUM_PHASES   = 13;
    localparam int DWELL_CYCLES = 11;
    localparam logic [NUM_PHASES-1:0] MUL_SCHEDULE = 13'h00FF;

    function automatic int unsigned ceil_log2(input int unsigned v);
        int unsigned r;
        r = 0;
        while ((1 << r) < v) r++;
        return (r == 0) ? 1 : r;
    endfunction
endpackage

// File: rtl/iter_seq_dwell_counter.sv
module iter_seq_dwell_counter #(
    parameter int DWELL = iter_seq_pkg::DWELL_CYCLES,
    localparam int CW   = iter_seq_pkg::ceil_log2(DWELL)
) (
    input  logic          clk,
    input  logic          rst,
    output logic [CW-1:0] tick_q,
    output logic [CW-1:0] tick_nxt,
    output logic          phase_done
);
    localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

    always_comb begin
        phase_done = (tick_q == LAST);
        tick_nxt   = phase_done ? '0 : tick_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) tick_q <= '0;
        else     tick_q <= tick_nxt;
    end

    AST_TICK_RANGE: assert property (@(posedge clk) disable iff (rst)
        tick_q <= LAST); // R2
endmodule

// File: rtl/iter_seq_phase_ring.sv
module iter_seq_phase_ring #(
    parameter int PHASES = iter_seq_pkg::NUM_PHASES,
    localparam int SW    = iter_seq_pkg::ceil_log2(PHASES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          advance,
    output logic [SW-1:0] phase_q,
    output logic [SW-1:0] phase_nxt
);
    localparam logic [SW-1:0] TOP = SW'(PHASES - 1);

    always_comb begin
        if (!advance)          phase_nxt = phase_q;
        else if (phase_q == TOP) phase_nxt = '0;
        else                   phase_nxt = phase_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= phase_nxt;
    end

    AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(phase_q)); // R2
    AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (advance && phase_q == TOP) |=> phase_q == '0); // R3
    AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (rst)
        phase_q <= TOP); // R3
endmodule

// File: rtl/iter_seq_strobe_gen.sv
module iter_seq_strobe_gen #(
    parameter int PHASES = iter_seq_pkg::NUM_PHASES,
    parameter int DWELL  = iter_seq_pkg::DWELL_CYCLES,
    parameter logic [PHASES-1:0] MUL_MASK = iter_seq_pkg::MUL_SCHEDULE,
    localparam int SW    = iter_seq_pkg::ceil_log2(PHASES),
    localparam int CW    = iter_seq_pkg::ceil_log2(DWELL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SW-1:0]     phase_q,
    input  logic [SW-1:0]     phase_nxt,
    input  logic [CW-1:0]     tick_q,
    input  logic [CW-1:0]     tick_nxt,
    output logic              mul_en,
    output logic [PHASES-1:0] load_stb
);
    localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

    logic              closing;
    logic [PHASES-1:0] stb_nxt;
    logic              mul_nxt;

    assign closing = (tick_nxt == LAST);

    for (genvar k = 0; k < PHASES; k++) begin : g_stb
        assign stb_nxt[k] = closing && (phase_nxt == SW'(k));
    end

    always_comb begin
        mul_nxt = 1'b0;
        for (int k = 0; k < PHASES; k++)
            if (phase_nxt == SW'(k)) mul_nxt = MUL_MASK[k];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_stb <= '0;
            mul_en   <= 1'b0;
        end else begin
            load_stb <= stb_nxt;
            mul_en   <= mul_nxt;
        end
    end

    AST_STB_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
        $onehot0(load_stb)); // R5
    AST_STB_LAST_TICK: assert property (@(posedge clk) disable iff (rst)
        (|load_stb) |-> (tick_q == LAST)); // R4
    AST_STB_PULSE: assert property (@(posedge clk) disable iff (rst)
        (|load_stb) |=> !(|load_stb)); // R4
endmodule

// File: rtl/iter_sequencer.sv
module iter_sequencer #(
    parameter int NUM_PHASES = iter_seq_pkg::NUM_PHASES,
    parameter int DWELL      = iter_seq_pkg::DWELL_CYCLES,
    parameter logic [NUM_PHASES-1:0] MUL_MASK = iter_seq_pkg::MUL_SCHEDULE,
    localparam int SW        = iter_seq_pkg::ceil_log2(NUM_PHASES),
    localparam int CW        = iter_seq_pkg::ceil_log2(DWELL)
) (
    input  logic                  clk,
    input  logic                  rst,
    output logic [SW-1:0]         phase_sel,
    output logic                  mul_en,
    output logic [NUM_PHASES-1:0] load_stb
);
    logic [CW-1:0] tick_q, tick_nxt;
    logic          phase_done;
    logic [SW-1:0] phase_q, phase_nxt;

    iter_seq_dwell_counter #(.DWELL(DWELL)) i_dwell (
        .clk(clk), .rst(rst),
        .tick_q(tick_q), .tick_nxt(tick_nxt), .phase_done(phase_done)
    );

    iter_seq_phase_ring #(.PHASES(NUM_PHASES)) i_ring (
        .clk(clk), .rst(rst), .advance(phase_done),
        .phase_q(phase_q), .phase_nxt(phase_nxt)
    );

    iter_seq_strobe_gen #(.PHASES(NUM_PHASES), .DWELL(DWELL), .MUL_MASK(MUL_MASK)) i_stb (
        .clk(clk), .rst(rst),
        .phase_q(phase_q), .phase_nxt(phase_nxt),
        .tick_q(tick_q), .tick_nxt(tick_nxt),
        .mul_en(mul_en), .load_stb(load_stb)
    );

    assign phase_sel = phase_q;

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (phase_sel == '0 && load_stb == '0 && !mul_en)); // R1
    AST_STB_PHASE: assert property (@(posedge clk) disable iff (rst)
        (|load_stb) |-> load_stb[phase_sel]); // R4
endmodule

// File: tb/test_iter_sequencer.sv
module test_iter_sequencer;
    localparam int NP = 13;
    localparam int DW = 11;
    localparam logic [NP-1:0] MASK = 13'h00FF;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [3:0]    phase_sel;
    logic          mul_en;
    logic [NP-1:0] load_stb;

    int errors = 0;
    int checks = 0;
    int t = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    iter_sequencer i_iter_sequencer (
        .clk(clk), .rst(rst),
        .phase_sel(phase_sel), .mul_en(mul_en), .load_stb(load_stb)
    );

    function automatic int exp_phase(int tt);
        return (tt / DW) % NP;
    endfunction

    function automatic logic [NP-1:0] exp_stb(int tt);
        return ((tt % DW) == DW - 1) ? (NP'(1) << exp_phase(tt)) : '0;
    endfunction

    function automatic logic exp_mul(int tt);
        return (tt == 0) ? 1'b0 : MASK[exp_phase(tt)];
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s at t=%0d: actual=%0h expected=%0h", req, what, t, act, exp);
        end
    endtask

    task automatic check_model(bit after_mid_reset);
        string rs, rb, rm;
        rs = ((t % DW) == 0 && t != 0) ? "R3" : "R2";
        rb = ((t % DW) == DW - 1) ? "R4" : "R5";
        rm = (t == 0) ? "R1" : "R6";
        if (after_mid_reset && t < DW) begin
            rs = "R7"; rb = "R7";
        end
        check(rs, "phase_sel", int'(phase_sel), exp_phase(t));
        check(rb, "load_stb", int'(load_stb), int'(exp_stb(t)));
        check(rm, "mul_en", int'(mul_en), int'(exp_mul(t)));
    endtask

    task automatic hold_reset(int n);
        rst = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            check("R1", "reset phase_sel", int'(phase_sel), 0);
            check("R1", "reset load_stb", int'(load_stb), 0);
            check("R1", "reset mul_en", int'(mul_en), 0);
        end
        rst = 1'b0;
        t = 0;
    endtask

    task automatic run(int n, bit after_mid_reset);
        check_model(after_mid_reset);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            t++;
            check_model(after_mid_reset);
        end
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        @(negedge clk);
        hold_reset(2);
        // directed: three full iterations, covering every wrap 12 -> 0
        run(3 * NP * DW + 5, 1'b0);
        // directed corners: reset just before a strobe and right on a boundary
        hold_reset(1);
        run(DW - 2, 1'b1);
        hold_reset(1);
        run(DW * 12, 1'b1);
        hold_reset(1);
        run(2 * DW, 1'b1);
        // random mid-iteration resets (R7)
        for (int s = 0; s < 8; s++) begin
            hold_reset(1 + ($urandom % 3));
            run(20 + ($urandom % 300), 1'b1);
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule